// File: doc/BRIEF.md
# Four-Bank Flow-Through Synchronous SRAM

This block is a behavioural, synthesizable model of a synchronous static memory split into four banks. Every word is 72 bits wide: 64 data bits in eight byte lanes, plus one parity bit per lane. Each bank has an active-low enable that is sampled at the clock. Each bank also has an active-high sleep input that acts without the clock. Address, write controls and write data are all captured on the same rising edge. A write therefore completes at the edge that presents it. A read returns its word during the cycle that follows its edge, with no output register in the path.

The data bus is modelled as three signals: separate input and output buses and a drive flag. The drive flag is gated by an asynchronous active-low output enable. An undriven bus reads as zero. Each clock is one independent access, which is the non-burst way of using such a memory. Any burst address sequencing is left to the logic around the block.

If more than one bank enable is low at an edge, the lowest-numbered bank is used and an error flag is raised.

Top module: `quad_bank_ft_sram`

## Requirements
- R1: While the synchronous active-low reset is applied, and in the cycle after it, dq_drive is 0 and sel_err is 0.
- R2: A write at edge N to bank b, address a, stores the selected lanes of dq_in. A later read of bank b, address a, returns them.
- R3: A read registered at edge N drives the stored word on dq_out, with dq_drive 1, during the cycle after edge N. No further edge is needed.
- R4: Lane k covers data bits 8k+7..8k and parity bit 64+k. Lanes are selected as follows:
  - glob_wr_n=0 writes all eight lanes.
  - Otherwise, lane_gate_n=0 writes the lanes whose lane_wr_n bit is 0.
  - Lanes that are not selected keep their contents.
  - A cycle that selects no lane is a read.
- R5: dq_drive is 1 only while oe_n is 0, and it follows oe_n without a clock. While dq_drive is 0, dq_out is all zeros.
- R6: An edge with every bank enable high is deselected. In the following cycle dq_drive is 0, and no memory word changes.
- R7: In the cycle after a write, dq_drive is 0.
- R8: A bank whose sleep input is 1 at an edge ignores the access at that edge: a write stores nothing and a read is not driven. Raising the sleep input of the bank being read drops dq_drive at once.
- R9: A bank keeps its contents while asleep. Once its sleep input returns to 0, the bank is read and written normally.
- R10: If two or more bank enables are low at an edge:
  - the lowest-numbered enabled bank performs the access;
  - sel_err is 1 during the following cycle.
  
  sel_err is 0 after any edge with at most one enable low.
- R11: Every edge is a complete, independent access. A read on the edge directly after a write to the same word returns the new data.
- R12: The banks hold separate storage. The same address in different banks keeps different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control registers |
| bank_en_n | input | NUM_BANKS | Active-low bank enables, sampled at the edge |
| bank_sleep | input | NUM_BANKS | Active-high per-bank sleep, asynchronous |
| addr | input | log2(DEPTH) | Word address within a bank |
| glob_wr_n | input | 1 | Active-low write of all lanes |
| lane_gate_n | input | 1 | Active-low gate for per-lane writes |
| lane_wr_n | input | LANES | Active-low per-lane write selects |
| dq_in | input | 9*LANES | Write data: data lanes low, parity bits high |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | 9*LANES | Read data, zero when not driven |
| dq_drive | output | 1 | High while the block drives the bus |
| sel_err | output | 1 | More than one bank was enabled at the last edge |

## Verification
The bench builds the block with four banks, eight lanes and a depth of four words. This gives sixteen words in total, so every word of every bank is written and read back with a distinct pattern. With that depth, all 256 lane-select patterns can be swept on one word, and all 16 bank-enable combinations can be swept for the priority and error rules. The small depth also leaves room to interleave sleep, deselect and output-enable changes, and to check after each of them that the other banks' words are untouched.

// File: rtl/qbs_pkg.sv
// Package: shared definitions for the four-bank flow-through SRAM.
// Assumes: nothing beyond IEEE 1800-2017.
package qbs_pkg;

    // Bits in one data lane; each lane also owns one parity bit.
    localparam int LANE_BITS = 8;

    // Kind of access decoded at a clock edge.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;

endpackage

// File: rtl/qbs_ctl.sv
// qbs_ctl: decodes the access presented at each edge.
// It picks the bank by priority, expands the lane selects into a bit mask,
// gates writes by bank sleep, and registers the read context that the
// flow-through output path uses during the next cycle.
// Assumes: NB >= 1; the data lanes sit low in the word and the parity bits high.
module qbs_ctl
    import qbs_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 4,
    parameter int NL = 8,
    localparam int W  = NL * (LANE_BITS + 1),
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bank_en_n,
    input  logic [NB-1:0] bank_sleep,
    input  logic [AW-1:0] addr,
    input  logic          glob_wr_n,
    input  logic          lane_gate_n,
    input  logic [NL-1:0] lane_wr_n,
    output logic [NB-1:0] wr_bank_en,
    output logic [W-1:0]  wr_mask,
    output logic [BW-1:0] rd_bank_q,
    output logic [AW-1:0] rd_addr_q,
    output logic          rd_live_q,
    output logic          err_q
);

    logic [NB-1:0] act;
    logic [BW-1:0] pick_idx;
    logic          pick_hit;
    logic          multi;
    logic [NL-1:0] lane_sel;
    cyc_kind_t     kind;

    assign act   = ~bank_en_n;
    assign multi = |(act & (act - 1'b1));

    // Priority pick: the lowest-numbered enabled bank wins.
    always_comb begin
        pick_idx = '0;
        pick_hit = 1'b0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (act[i]) begin
                pick_idx = BW'(i);
                pick_hit = 1'b1;
            end
        end
    end

    // Lane selection: a global write overrides the gated per-lane selects.
    always_comb begin
        if (!glob_wr_n)        lane_sel = '1;
        else if (!lane_gate_n) lane_sel = ~lane_wr_n;
        else                   lane_sel = '0;
    end

    // Access kind: deselected, write if any lane is selected, else read.
    always_comb begin
        if (!pick_hit)      kind = CYC_IDLE;
        else if (|lane_sel) kind = CYC_WRITE;
        else                kind = CYC_READ;
    end

    for (genvar k = 0; k < NL; k++) begin : g_mask
        assign wr_mask[k*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_sel[k]}};
        assign wr_mask[NL*LANE_BITS + k]         = lane_sel[k];
    end

    for (genvar i = 0; i < NB; i++) begin : g_wen
        assign wr_bank_en[i] = (kind == CYC_WRITE) && (pick_idx == BW'(i)) && !bank_sleep[i];
    end

    // Read context register: feeds the flow-through output during the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_live_q <= 1'b0;
            rd_bank_q <= '0;
            rd_addr_q <= '0;
            err_q     <= 1'b0;
        end else begin
            rd_live_q <= (kind == CYC_READ) && !bank_sleep[pick_idx];
            rd_bank_q <= pick_idx;
            rd_addr_q <= addr;
            err_q     <= multi;
        end
    end

endmodule

// File: rtl/qbs_bank.sv
// qbs_bank: the storage of one bank.
// It has one bit-masked write port, written at the edge,
// and one combinational read port.
// Assumes: DEPTH is a power of two; the contents are not reset.
module qbs_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 72,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wmask,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Early write: merge the masked bits into the word at this edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end

    // Flow-through read: the word follows the registered address with no stage.
    assign rdata = mem[raddr];

endmodule

// File: rtl/qbs_out.sv
// qbs_out: output path.
// It selects the word of the bank read at the last edge, and drives it only
// while the output enable is low and that bank is awake.
// Assumes: rd_bank < NB; banks' read words are packed bank 0 lowest.
module qbs_out #(
    parameter int NB = 4,
    parameter int W  = 72,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB*W-1:0] bank_rdata,
    input  logic [BW-1:0]   rd_bank,
    input  logic            rd_live,
    input  logic [NB-1:0]   bank_sleep,
    input  logic            oe_n,
    output logic [W-1:0]    dq_out,
    output logic            dq_drive
);

    // Asynchronous drive gate: no clock between oe_n or sleep and the bus.
    always_comb begin
        dq_drive = rd_live && !oe_n && !bank_sleep[rd_bank];
        dq_out   = dq_drive ? bank_rdata[rd_bank*W +: W] : '0;
    end

endmodule

// File: rtl/quad_bank_ft_sram.sv
// quad_bank_ft_sram: four-bank synchronous SRAM with flow-through reads and
// early self-timed writes.
// It has registered bank enables, asynchronous per-bank sleep and an
// asynchronous output enable.
// Assumes: DEPTH is a power of two; one access per clock; burst sequencing is
// done outside the block.
module quad_bank_ft_sram
    import qbs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 16,
    parameter int LANES     = 8,
    localparam int AW       = $clog2(DEPTH),
    localparam int WORD_W   = LANES * (LANE_BITS + 1),
    localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_en_n,
    input  logic [NUM_BANKS-1:0] bank_sleep,
    input  logic [AW-1:0]        addr,
    input  logic                 glob_wr_n,
    input  logic                 lane_gate_n,
    input  logic [LANES-1:0]     lane_wr_n,
    input  logic [WORD_W-1:0]    dq_in,
    input  logic                 oe_n,
    output logic [WORD_W-1:0]    dq_out,
    output logic                 dq_drive,
    output logic                 sel_err
);

    logic [NUM_BANKS-1:0]        wr_bank_en;
    logic [WORD_W-1:0]           wr_mask;
    logic [BW-1:0]               rd_bank_q;
    logic [AW-1:0]               rd_addr_q;
    logic                        rd_live_q;
    logic [NUM_BANKS*WORD_W-1:0] bank_rdata;

    qbs_ctl #(.NB(NUM_BANKS), .AW(AW), .NL(LANES)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_en_n  (bank_en_n),
        .bank_sleep (bank_sleep),
        .addr       (addr),
        .glob_wr_n  (glob_wr_n),
        .lane_gate_n(lane_gate_n),
        .lane_wr_n  (lane_wr_n),
        .wr_bank_en (wr_bank_en),
        .wr_mask    (wr_mask),
        .rd_bank_q  (rd_bank_q),
        .rd_addr_q  (rd_addr_q),
        .rd_live_q  (rd_live_q),
        .err_q      (sel_err)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        qbs_bank #(.DEPTH(DEPTH), .W(WORD_W)) u_bank (
            .clk  (clk),
            .we   (wr_bank_en[b]),
            .waddr(addr),
            .wmask(wr_mask),
            .wdata(dq_in),
            .raddr(rd_addr_q),
            .rdata(bank_rdata[b*WORD_W +: WORD_W])
        );
    end

    qbs_out #(.NB(NUM_BANKS), .W(WORD_W)) u_out (
        .bank_rdata(bank_rdata),
        .rd_bank   (rd_bank_q),
        .rd_live   (rd_live_q),
        .bank_sleep(bank_sleep),
        .oe_n      (oe_n),
        .dq_out    (dq_out),
        .dq_drive  (dq_drive)
    );

endmodule

// File: rtl/qbs_chk.sv
// qbs_chk: protocol checker for quad_bank_ft_sram, bound to every instance.
// It watches only the top-level ports, sampled at the rising clock edge.
// Assumes: reset is held low from time zero.
module qbs_chk #(
    parameter int NB = 4,
    parameter int NL = 8,
    parameter int W  = 72
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB-1:0] bank_en_n,
    input logic [NB-1:0] bank_sleep,
    input logic          glob_wr_n,
    input logic          lane_gate_n,
    input logic [NL-1:0] lane_wr_n,
    input logic          oe_n,
    input logic [W-1:0]  dq_out,
    input logic          dq_drive,
    input logic          sel_err
);

    logic is_wr;
    logic one_en;
    // Port-level view of whether the presented cycle writes any lane.
    assign is_wr  = !glob_wr_n || (!lane_gate_n && !(&lane_wr_n));
    assign one_en = ($countones(~bank_en_n) == 1);

    // R5: the bus is driven only with the output enable low
    a_r5_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> !oe_n);

    // R5: an undriven bus reads as zero
    a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_drive |-> (dq_out == '0));

    // R6: a deselected edge leaves the bus undriven
    a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_en_n) |=> !dq_drive);

    // R7: no drive in the cycle after a write
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&bank_en_n) && is_wr) |=> !dq_drive);

    // R8: a sleeping bank ignores a read
    a_r8_sleep_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (one_en && |(bank_sleep & ~bank_en_n)) |=> !dq_drive);

    // R3: an accepted read drives in the next cycle, subject to oe_n and sleep
    a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (one_en && !is_wr && !(|(bank_sleep & ~bank_en_n)))
        |=> (dq_drive == (!oe_n && !(|(bank_sleep & $past(~bank_en_n))))));

    // R10: multiple enables raise the error flag for one cycle
    a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~bank_en_n) > 1) |=> sel_err);

    // R10: the flag stays clear after a legal selection
    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~bank_en_n) <= 1) |=> !sel_err);

endmodule

bind quad_bank_ft_sram qbs_chk #(.NB(NUM_BANKS), .NL(LANES), .W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_en_n  (bank_en_n),
    .bank_sleep (bank_sleep),
    .glob_wr_n  (glob_wr_n),
    .lane_gate_n(lane_gate_n),
    .lane_wr_n  (lane_wr_n),
    .oe_n       (oe_n),
    .dq_out     (dq_out),
    .dq_drive   (dq_drive),
    .sel_err    (sel_err)
);

// File: tb/sim_quad_bank_ft_sram.sv
// sim_quad_bank_ft_sram: self-checking bench.
// Configuration: four banks, eight lanes, depth of four words.
// The bench drives inputs 2 ns after a rising edge and samples outputs before the next edge.
module sim_quad_bank_ft_sram;

    localparam int NB = 4;
    localparam int DEPTH = 4;
    localparam int NL = 8;
    localparam int AW = 2;
    localparam int W = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] bank_en_n = '1;
    logic [NB-1:0] bank_sleep = '0;
    logic [AW-1:0] addr = '0;
    logic          glob_wr_n = 1'b1;
    logic          lane_gate_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic [W-1:0]  dq_in = '0;
    logic          oe_n = 1'b0;
    logic [W-1:0]  dq_out;
    logic          dq_drive;
    logic          sel_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_mem [NB][DEPTH];

    always #5 clk = ~clk;

    quad_bank_ft_sram #(.NUM_BANKS(NB), .DEPTH(DEPTH), .LANES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .bank_en_n(bank_en_n), .bank_sleep(bank_sleep),
        .addr(addr), .glob_wr_n(glob_wr_n), .lane_gate_n(lane_gate_n),
        .lane_wr_n(lane_wr_n), .dq_in(dq_in), .oe_n(oe_n),
        .dq_out(dq_out), .dq_drive(dq_drive), .sel_err(sel_err)
    );

    function automatic logic [W-1:0] pat(int b, int a, int s);
        logic [W-1:0] w;
        w[63:0]  = 64'h9E3779B97F4A7C15 * 64'(b * 64 + a * 8 + s + 1);
        w[71:64] = 8'(b * 31 + a * 7 + s * 3 + 5);
        return w;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One clocked access; returns 2 ns after the edge.
    task automatic cyc(logic [NB-1:0] en, int a, logic gw, logic gate,
                       logic [NL-1:0] lanes, logic [W-1:0] d);
        bank_en_n = en; addr = AW'(a); glob_wr_n = gw; lane_gate_n = gate;
        lane_wr_n = lanes; dq_in = d;
        @(posedge clk);
        #2;
    endtask

    task automatic full_wr(int b, int a, logic [W-1:0] d);
        cyc(~(NB'(1) << b), a, 1'b0, 1'b1, '1, d);
        exp_mem[b][a] = d;
    endtask

    task automatic rd_chk(int b, int a, string req);
        cyc(~(NB'(1) << b), a, 1'b1, 1'b1, '0, pat(9, 9, a));
        check(req, W'(dq_drive), W'(1));
        check(req, dq_out, exp_mem[b][a]);
    endtask

    task automatic idle();
        cyc('1, 0, 1'b1, 1'b1, '1, '0);
    endtask

    initial begin
        // R1: reset state, even with a read presented
        bank_en_n = 4'b1110;
        repeat (3) @(posedge clk);
        #2;
        check("R1 drive in reset", W'(dq_drive), W'(0));
        check("R1 err in reset", W'(sel_err), W'(0));
        bank_en_n = '1;
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 drive after reset", W'(dq_drive), W'(0));
        check("R1 err after reset", W'(sel_err), W'(0));

        // R2 R7: fill every word of every bank with full writes
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < DEPTH; a++) begin
                full_wr(b, a, pat(b, a, 0));
                check("R7 no drive after write", W'(dq_drive), W'(0));
            end
        // R2 R3 R12: back-to-back reads of every word
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < DEPTH; a++) rd_chk(b, a, "R2 R12 readback");

        // R11: read right after write of the same word
        full_wr(0, 3, pat(0, 3, 50));
        rd_chk(0, 3, "R11 read after write");
        full_wr(2, 1, pat(2, 1, 51));
        rd_chk(3, 1, "R11 other bank between");
        rd_chk(2, 1, "R11 written word");

        // R3 R5: flow-through with async output enable
        rd_chk(1, 2, "R3 flow-through");
        oe_n = 1'b1; #1;
        check("R5 oe high drive", W'(dq_drive), W'(0));
        check("R5 oe high bus", dq_out, '0);
        oe_n = 1'b0; #1;
        check("R5 oe low drive", W'(dq_drive), W'(1));
        check("R5 oe low data", dq_out, exp_mem[1][2]);

        // R4: sweep every lane pattern on bank 1 address 2
        for (int p = 0; p < 256; p++) begin
            logic [W-1:0] d;
            d = pat(1, 2, p + 100);
            cyc(4'b1101, 2, 1'b1, 1'b0, NL'(p), d);
            if (p == 255) begin
                check("R4 no lane is read", W'(dq_drive), W'(1));
                check("R4 no lane data", dq_out, exp_mem[1][2]);
            end else begin
                check("R7 lane write quiet", W'(dq_drive), W'(0));
                for (int k = 0; k < NL; k++)
                    if (!p[k]) begin
                        exp_mem[1][2][k*8 +: 8] = d[k*8 +: 8];
                        exp_mem[1][2][64 + k]   = d[64 + k];
                    end
            end
            rd_chk(1, 2, "R4 lane merge");
        end
        // R4: gate high ignores lane selects
        cyc(4'b1101, 2, 1'b1, 1'b1, '0, pat(7, 7, 7));
        check("R4 gate high is read", W'(dq_drive), W'(1));
        check("R4 gate high data", dq_out, exp_mem[1][2]);
        // R4: global write overrides partial lanes
        cyc(4'b1101, 2, 1'b0, 1'b0, 8'hFE, pat(1, 2, 999));
        exp_mem[1][2] = pat(1, 2, 999);
        rd_chk(1, 2, "R4 global write");

        // R6: deselected edge with write controls active
        cyc('1, 0, 1'b0, 1'b0, '0, pat(5, 5, 5));
        check("R6 deselect no drive", W'(dq_drive), W'(0));
        for (int b = 0; b < NB; b++) rd_chk(b, 0, "R6 contents kept");

        // R8: sleeping bank ignores write and read
        bank_sleep = 4'b0100;
        cyc(4'b1011, 0, 1'b0, 1'b1, '1, pat(2, 0, 77));
        cyc(4'b1011, 0, 1'b1, 1'b1, '1, '0);
        check("R8 asleep read not driven", W'(dq_drive), W'(0));
        rd_chk(3, 0, "R8 awake bank unaffected");
        bank_sleep[3] = 1'b1; #1;
        check("R8 async sleep drop", W'(dq_drive), W'(0));
        check("R8 async sleep bus", dq_out, '0);
        bank_sleep[3] = 1'b0; #1;
        check("R8 sleep released", dq_out, exp_mem[3][0]);

        // R9: contents kept through sleep, access resumes
        bank_sleep = '0;
        rd_chk(2, 0, "R9 kept through sleep");
        full_wr(2, 0, pat(2, 0, 78));
        rd_chk(2, 0, "R9 write resumes");

        // R10: sweep every enable combination on address 1
        for (int p = 0; p < 16; p++) begin
            logic [NB-1:0] act;
            int lo;
            act = ~NB'(p);
            lo = -1;
            for (int i = NB - 1; i >= 0; i--) if (act[i]) lo = i;
            cyc(NB'(p), 1, 1'b1, 1'b1, '1, '0);
            check("R10 err flag", W'(sel_err), W'($countones(act) > 1));
            if (lo < 0) check("R6 none enabled", W'(dq_drive), W'(0));
            else check("R10 lowest bank data", dq_out, exp_mem[lo][1]);
        end
        // R10: multi-enable write reaches only the lowest bank
        cyc(4'b1001, 3, 1'b0, 1'b1, '1, pat(1, 3, 321));
        exp_mem[1][3] = pat(1, 3, 321);
        check("R10 err after write", W'(sel_err), W'(1));
        rd_chk(1, 3, "R10 lowest written");
        check("R10 err cleared", W'(sel_err), W'(0));
        rd_chk(2, 3, "R10 other untouched");
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule